// File: doc/BRIEF.md
# Posted Write Queue with Flush Handshake

This block holds write transactions that one side of a bus bridge has already completed as a target, so the other side can issue them later as an initiator. Each stored entry carries an address, a data word, per-byte enables and a flag that marks the final beat of a burst. Entries leave through a valid/ready drain port in exactly the order they arrived. A bridge uses one instance for each direction of traffic.

An outside agent can ask the block to stop taking new writes by raising `flush_req`. The block lets any burst that is still being accepted run to its final beat. It then raises `flush_ack` and refuses further writes. `flush_ack` stays high until every queued entry has drained. After the queue is empty, the acknowledge drops. Posting starts again once the agent has lowered its request.

Top module: `posted_wr_buf`

## Requirements
- R1: After synchronous reset the queue is empty: `drn_valid` is 0, `flush_ack` is 0 and `enq_ready` is 1.
- R2: Drained entries come out in arrival order, with address, data, byte enables and last flag unchanged.
- R3: An entry is stored only on a cycle where `enq_valid` and `enq_ready` are both 1. `enq_ready` is 0 while DEPTH entries are held, so a write offered to a full queue is not stored.
- R4: `drn_valid` is 1 exactly when at least one entry is held. While `drn_valid` is 1 and `drn_ready` is 0, the presented entry does not change.
- R5: When `flush_req` is 1 and no burst is open (the last accepted entry had `enq_last`=1, or nothing was accepted since reset), `enq_ready` is 0 in that same cycle, and `flush_ack` is 1 from the next clock edge on.
- R6: When `flush_req` rises while a burst is open, `enq_ready` keeps following queue space until the entry with `enq_last`=1 is accepted. `flush_ack` is 1 from the clock edge that accepts that entry.
- R7: While `flush_ack` is 1, `enq_ready` is 0. `flush_ack` stays 1 while any entry is held, and falls on the first clock edge at which the queue is sampled empty.
- R8: After `flush_ack` falls, `enq_ready` stays 0 for as long as `flush_req` stays 1. `enq_ready` returns to 1 on the clock edge that samples `flush_req` at 0.
- R9: If `flush_req` is withdrawn before an open burst ends, no acknowledge is given and posting continues normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Write entry offered |
| enq_ready | output | 1 | Entry can be accepted this cycle |
| enq_addr | input | 32 | Write address |
| enq_data | input | 32 | Write data |
| enq_be | input | 4 | Byte enables, bit n for data byte n |
| enq_last | input | 1 | Final beat of a burst |
| drn_valid | output | 1 | Head entry available |
| drn_ready | input | 1 | Initiator side takes the head entry |
| drn_addr | output | 32 | Head entry address |
| drn_data | output | 32 | Head entry data |
| drn_be | output | 4 | Head entry byte enables |
| drn_last | output | 1 | Head entry burst-end flag |
| flush_req | input | 1 | Request to stop posting and empty the queue |
| flush_ack | output | 1 | Posting stopped; held until the queue is empty |

## Verification
The queue is driven with a short mixed sequence, with a stalled head, and with a fill to capacity followed by an extra offered write. These show in turn whether ordering is kept, whether the head entry is held steady under back-pressure, and whether the full limit drops writes. Flush is tried with the request arriving between bursts and again in the middle of a burst. Comparing the cycle at which the acknowledge appears in these two cases shows whether the block waits for the burst to end only when a burst is actually open. A request that is withdrawn mid-burst, and a request held past the drain, separate the abort path from the hold-off-then-resume path.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic              last;
    } wr_entry_t;

    typedef enum logic [1:0] {
        ST_POST   = 2'd0,
        ST_FINISH = 2'd1,
        ST_ACK    = 2'd2,
        ST_HOLD   = 2'd3
    } flush_st_e;

    // Burst state after this cycle, given an accept and its last flag
    function automatic logic burst_after(input logic open_now,
                                         input logic fire,
                                         input logic last);
        return fire ? !last : open_now;
    endfunction
endpackage

// File: rtl/pwb_store.sv
module pwb_store
    import pwb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wr_entry_t push_entry,
    input  logic      pop,
    output wr_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    wr_entry_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);
endmodule

// File: rtl/pwb_flush_ctl.sv
module pwb_flush_ctl
    import pwb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush_req,
    input  logic enq_fire,
    input  logic enq_last,
    input  logic store_empty,
    output logic post_open,
    output logic flush_ack
);
    flush_st_e state, state_nxt;
    logic      burst_open, burst_nxt;

    assign burst_nxt = burst_after(burst_open, enq_fire, enq_last);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_POST:   if (flush_req) state_nxt = burst_nxt ? ST_FINISH : ST_ACK;
            ST_FINISH: begin
                if (!flush_req)      state_nxt = ST_POST;
                else if (!burst_nxt) state_nxt = ST_ACK;
            end
            ST_ACK:    if (store_empty) state_nxt = flush_req ? ST_HOLD : ST_POST;
            ST_HOLD:   if (!flush_req) state_nxt = ST_POST;
            default:   state_nxt = ST_POST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_POST;
            burst_open <= 1'b0;
        end else begin
            state      <= state_nxt;
            burst_open <= burst_nxt;
        end
    end

    assign post_open = ((state == ST_POST) && !(flush_req && !burst_open))
                     || (state == ST_FINISH);
    assign flush_ack = (state == ST_ACK);
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf
    import pwb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    input  logic [BE_W-1:0]   enq_be,
    input  logic              enq_last,
    output logic              drn_valid,
    input  logic              drn_ready,
    output logic [ADDR_W-1:0] drn_addr,
    output logic [DATA_W-1:0] drn_data,
    output logic [BE_W-1:0]   drn_be,
    output logic              drn_last,
    input  logic              flush_req,
    output logic              flush_ack
);
    wr_entry_t in_entry, head;
    logic      empty, full, post_open, fire, pop;

    assign in_entry = '{addr: enq_addr, data: enq_data, be: enq_be, last: enq_last};
    assign enq_ready = post_open && !full;
    assign fire      = enq_valid && enq_ready;
    assign drn_valid = !empty;
    assign pop       = drn_valid && drn_ready;

    pwb_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (fire),
        .push_entry (in_entry),
        .pop        (pop),
        .head       (head),
        .empty      (empty),
        .full       (full)
    );

    pwb_flush_ctl u_flush (
        .clk         (clk),
        .rst         (rst),
        .flush_req   (flush_req),
        .enq_fire    (fire),
        .enq_last    (enq_last),
        .store_empty (empty),
        .post_open   (post_open),
        .flush_ack   (flush_ack)
    );

    assign drn_addr = head.addr;
    assign drn_data = head.data;
    assign drn_be   = head.be;
    assign drn_last = head.last;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
    import pwb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              enq_valid,
    input logic              enq_ready,
    input logic              enq_last,
    input logic              drn_valid,
    input logic              drn_ready,
    input logic [ADDR_W-1:0] drn_addr,
    input logic [DATA_W-1:0] drn_data,
    input logic [BE_W-1:0]   drn_be,
    input logic              drn_last,
    input logic              flush_req,
    input logic              flush_ack
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    logic [CNT_W-1:0] held;
    logic             open_seen;
    logic             acc, take;

    assign acc  = enq_valid && enq_ready;
    assign take = drn_valid && drn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            open_seen <= 1'b0;
        end else begin
            held      <= held + CNT_W'(acc) - CNT_W'(take);
            if (acc) open_seen <= !enq_last;
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (held == CNT_W'(DEPTH)) |-> !enq_ready);

    p_valid_tracks_r4: assert property (@(posedge clk) disable iff (rst)
        (held != '0) == drn_valid);

    p_head_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_addr) &&
            $stable(drn_data) && $stable(drn_be) && $stable(drn_last)));

    p_quick_ack_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(flush_req) && !open_seen && !flush_ack) |=> flush_ack);

    p_ack_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        flush_ack |-> !enq_ready);

    p_ack_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (flush_ack && drn_valid) |=> flush_ack);
endmodule

bind posted_wr_buf pwb_checker #(.DEPTH(DEPTH)) u_pwb_chk (
    .clk       (clk),
    .rst       (rst),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .enq_last  (enq_last),
    .drn_valid (drn_valid),
    .drn_ready (drn_ready),
    .drn_addr  (drn_addr),
    .drn_data  (drn_data),
    .drn_be    (drn_be),
    .drn_last  (drn_last),
    .flush_req (flush_req),
    .flush_ack (flush_ack)
);

// File: tb/posted_wr_buf_bench.sv
module posted_wr_buf_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enq_valid = 1'b0;
    logic        enq_ready;
    logic [31:0] enq_addr = '0;
    logic [31:0] enq_data = '0;
    logic [3:0]  enq_be = '0;
    logic        enq_last = 1'b0;
    logic        drn_valid;
    logic        drn_ready = 1'b0;
    logic [31:0] drn_addr, drn_data;
    logic [3:0]  drn_be;
    logic        drn_last;
    logic        flush_req = 1'b0;
    logic        flush_ack;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    posted_wr_buf #(.DEPTH(DEPTH)) u_posted_wr_buf (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_addr(enq_addr), .enq_data(enq_data), .enq_be(enq_be), .enq_last(enq_last),
        .drn_valid(drn_valid), .drn_ready(drn_ready),
        .drn_addr(drn_addr), .drn_data(drn_data), .drn_be(drn_be), .drn_last(drn_last),
        .flush_req(flush_req), .flush_ack(flush_ack)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Offer one entry for one cycle; acc reports whether it was taken
    task automatic push(input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] b, input logic l, output logic acc);
        @(negedge clk);
        enq_valid = 1'b1; enq_addr = a; enq_data = d; enq_be = b; enq_last = l;
        #1 acc = enq_ready;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [31:0] a,
                              input logic [31:0] d, input logic [3:0] b, input logic l);
        @(negedge clk);
        drn_ready = 1'b1;
        #1;
        chk(req, "drn_valid", 64'(drn_valid), 64'd1);
        chk(req, "addr/data", {drn_addr, drn_data}, {a, d});
        chk(req, "be/last", 64'({drn_be, drn_last}), 64'({b, l}));
        @(negedge clk);
        drn_ready = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "enq_ready", 64'(enq_ready), 64'd1);
        chk("R1", "drn_valid", 64'(drn_valid), 64'd0);
        chk("R1", "flush_ack", 64'(flush_ack), 64'd0);
    endtask

    task automatic t_order;
        logic acc;
        push(32'h1000, 32'hAAAA_0001, 4'hF, 1'b0, acc); chk("R3", "acc0", 64'(acc), 64'd1);
        push(32'h1004, 32'hAAAA_0002, 4'h3, 1'b0, acc); chk("R3", "acc1", 64'(acc), 64'd1);
        push(32'h2000, 32'hBBBB_0003, 4'h8, 1'b1, acc); chk("R3", "acc2", 64'(acc), 64'd1);
        chk("R4", "valid after fill", 64'(drn_valid), 64'd1);
        pop_expect("R2", 32'h1000, 32'hAAAA_0001, 4'hF, 1'b0);
        pop_expect("R2", 32'h1004, 32'hAAAA_0002, 4'h3, 1'b0);
        pop_expect("R2", 32'h2000, 32'hBBBB_0003, 4'h8, 1'b1);
        chk("R4", "valid after drain", 64'(drn_valid), 64'd0);
    endtask

    task automatic t_stall;
        logic acc;
        push(32'h3000, 32'h1234_5678, 4'h5, 1'b1, acc);
        push(32'h3004, 32'h9ABC_DEF0, 4'hA, 1'b1, acc);
        repeat (3) begin
            @(negedge clk);
            chk("R4", "stalled head", {drn_addr, drn_data}, {32'h3000, 32'h1234_5678});
        end
        pop_expect("R4", 32'h3000, 32'h1234_5678, 4'h5, 1'b1);
        pop_expect("R2", 32'h3004, 32'h9ABC_DEF0, 4'hA, 1'b1);
    endtask

    task automatic t_full;
        logic acc;
        for (int i = 0; i < DEPTH; i++) begin
            push(32'h4000 + 32'(i * 4), 32'hC000_0000 + 32'(i), 4'(i), 1'b1, acc);
            chk("R3", "fill accept", 64'(acc), 64'd1);
        end
        push(32'h4FFC, 32'hDEAD_BEEF, 4'hF, 1'b1, acc);
        chk("R3", "full refuses", 64'(acc), 64'd0);
        for (int i = 0; i < DEPTH; i++)
            pop_expect("R3", 32'h4000 + 32'(i * 4), 32'hC000_0000 + 32'(i), 4'(i), 1'b1);
        chk("R3", "extra not stored", 64'(drn_valid), 64'd0);
    endtask

    task automatic t_flush_idle;
        logic acc;
        push(32'h5000, 32'h5555_0000, 4'hF, 1'b1, acc);
        push(32'h5004, 32'h5555_0001, 4'hF, 1'b1, acc);
        @(negedge clk);
        flush_req = 1'b1;
        enq_valid = 1'b1;
        #1;
        chk("R5", "ready drops with req", 64'(enq_ready), 64'd0);
        chk("R5", "ack not yet", 64'(flush_ack), 64'd0);
        @(negedge clk);
        chk("R5", "ack next clock", 64'(flush_ack), 64'd1);
        chk("R7", "ready low under ack", 64'(enq_ready), 64'd0);
        enq_valid = 1'b0;
        pop_expect("R7", 32'h5000, 32'h5555_0000, 4'hF, 1'b1);
        chk("R7", "ack held while data", 64'(flush_ack), 64'd1);
        pop_expect("R7", 32'h5004, 32'h5555_0001, 4'hF, 1'b1);
        chk("R7", "ack until empty sampled", 64'(flush_ack), 64'd1);
        chk("R7", "empty", 64'(drn_valid), 64'd0);
        @(negedge clk);
        chk("R7", "ack falls", 64'(flush_ack), 64'd0);
        chk("R8", "held off", 64'(enq_ready), 64'd0);
        @(negedge clk);
        chk("R8", "still held off", 64'(enq_ready), 64'd0);
        flush_req = 1'b0;
        #1 chk("R8", "not before edge", 64'(enq_ready), 64'd0);
        @(negedge clk);
        chk("R8", "posting resumes", 64'(enq_ready), 64'd1);
    endtask

    task automatic t_flush_burst;
        logic acc;
        push(32'h6000, 32'h6666_0000, 4'h1, 1'b0, acc);
        @(negedge clk);
        flush_req = 1'b1;
        #1 chk("R6", "ready in open burst", 64'(enq_ready), 64'd1);
        @(negedge clk);
        chk("R6", "no ack mid burst", 64'(flush_ack), 64'd0);
        push(32'h6004, 32'h6666_0001, 4'h2, 1'b0, acc); chk("R6", "mid beat", 64'(acc), 64'd1);
        chk("R6", "no ack yet", 64'(flush_ack), 64'd0);
        push(32'h6008, 32'h6666_0002, 4'h4, 1'b1, acc); chk("R6", "last beat", 64'(acc), 64'd1);
        chk("R6", "ack after last", 64'(flush_ack), 64'd1);
        chk("R7", "ready low", 64'(enq_ready), 64'd0);
        pop_expect("R2", 32'h6000, 32'h6666_0000, 4'h1, 1'b0);
        pop_expect("R2", 32'h6004, 32'h6666_0001, 4'h2, 1'b0);
        pop_expect("R2", 32'h6008, 32'h6666_0002, 4'h4, 1'b1);
        @(negedge clk);
        chk("R7", "ack falls", 64'(flush_ack), 64'd0);
        flush_req = 1'b0;
        @(negedge clk);
        chk("R8", "resumes", 64'(enq_ready), 64'd1);
    endtask

    task automatic t_flush_abort;
        logic acc;
        push(32'h7000, 32'h7777_0000, 4'hC, 1'b0, acc);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        chk("R9", "no ack", 64'(flush_ack), 64'd0);
        flush_req = 1'b0;
        @(negedge clk);
        chk("R9", "no ack after drop", 64'(flush_ack), 64'd0);
        chk("R9", "ready", 64'(enq_ready), 64'd1);
        push(32'h7004, 32'h7777_0001, 4'h3, 1'b1, acc); chk("R9", "accepted", 64'(acc), 64'd1);
        pop_expect("R9", 32'h7000, 32'h7777_0000, 4'hC, 1'b0);
        pop_expect("R9", 32'h7004, 32'h7777_0001, 4'h3, 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset;
        t_order;
        t_stall;
        t_full;
        t_flush_idle;
        t_flush_burst;
        t_flush_abort;
        repeat (2) @(negedge clk);
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run;
    end
endmodule